// File: doc/BRIEF.md
# Byte-Coded Low-Power Sequencer

This block sits beside a processor core and drives the enables that put the core into a low-power state: clock gating, retention and the power switch. It does not use a fixed sleep and wake state machine. Instead it steps through a short byte program that software loads into a local 32-byte sequence memory. Several mode programs can be packed into that memory back to back. Software chooses a mode by writing the byte index where that mode's program starts.

When the core reports that it has gone idle waiting for an interrupt, the engine starts at the programmed index and fetches one byte per divided clock tick. It executes each byte as it is fetched. A byte can:
- place a value on the power-control outputs,
- wait a programmable number of ticks,
- park the engine until a wake interrupt arrives,
- end the program, which releases the core.

All configuration goes over a simple 32-bit register bus. Reads are combinational and writes take effect on a single-cycle write strobe. The bus also returns a status word that gives the busy flag, the current index, the current state and a sticky error flag.

Top module: `lpseq_top`

## Requirements
- R1: While bit 0 of the control word (offset 0x30) is 0, a rising edge on `idleReq` starts nothing: `busy` stays 0 and `pwrCtl` stays 0.
- R2: With bit 0 of the control word set, a rising edge on `idleReq` starts execution at the byte index held in control bits 10:4. That index may point at any byte, whether or not it is word-aligned.
- R3: The sequence memory is eight 32-bit words at offsets 0x80 to 0x9C. Byte k of word w is command byte 4w+k, held in bits 8k+7:8k. The words read back as written.
- R4: The byte 0x0F ends the program. On the tick that fetches it, the engine clears `pwrCtl` to 0, pulses `coreRelease` high for exactly one cycle and drops `busy`.
- R5: A byte with bit 7 set parks the engine. `busy` stays 1 and `pwrCtl` holds its value until `wakeIrq` is seen high. The next byte is fetched on the first tick after that.
- R6: A byte 0x20 to 0x2F takes one tick, then waits D further ticks before the next fetch. D is 8-bit field j of the delay word (offset 0x34), held in bits 8j+7:8j, where j is bits 1:0 of the byte.
- R7: Any other byte copies its low 6 bits onto `pwrCtl`.
- R8: The engine fetches one byte per tick. A tick occurs every N clock cycles, where N is bits 7:0 of the configuration word (offset 0x08), and a value of 0 counts as 1. From the start edge to the terminator the engine is busy for T·N cycles, where T is the number of ticks used.
- R9: If the index reaches 32 without meeting a terminator, the engine stops and sets a sticky error flag (status bit 1). It also clears `pwrCtl` and pulses `coreRelease`. Only reset clears the flag.
- R10: The status word (offset 0x0C) returns the following fields; all other bits read 0:

| Bits | Content |
|---|---|
| 0 | busy |
| 1 | error |
| 10:4 | current byte index |
| 13:12 | state (00 idle, 01 running, 10 delaying, 11 waiting for wake) |

- R11: A rising edge on `idleReq` while the engine is busy is ignored.
- R12: A write to sequence memory during execution affects only bytes the engine has not yet fetched.
- R13: The configuration, control and delay words read back exactly as written, and all of them are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| idleReq | input | 1 | Core has entered wait-for-interrupt idle; its rising edge starts a program |
| wakeIrq | input | 1 | Wake interrupt, level-sensitive |
| pwrCtl | output | 6 | Power-control enables |
| coreRelease | output | 1 | One-cycle pulse that releases the core from the low-power state |
| busy | output | 1 | A program is executing |

## Verification
The main check is a set of program runs that use one packed memory image. The runs cross several start indices, both aligned and unaligned, with several divider values. A divider of 0 and a divider of 1 must give the same timing. The busy-cycle count of each run shows whether the tick scaling and the delay-field selection are right, and the last output value seen shows whether the correct program was executed.

Directed runs then cover the remaining behaviour:
- a run parked on a wait byte, during which the bench checks the status word, fires a spurious idle edge and rewrites both fetched and unfetched bytes;
- a run that falls off the end of memory, which checks the sticky error flag;
- an idle edge with the engine disabled.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 7;
  localparam int PWR_W    = 6;

  localparam logic [ADDR_W-1:0] OFS_CFG    = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CTL    = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_DLY    = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_SEQ    = 12'h080;

  localparam logic [7:0] CMD_END = 8'h0F;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RUN   = 2'b01,
    ST_DELAY = 2'b10,
    ST_WAIT  = 2'b11
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setPwr;   // load low bits of fetched byte onto outputs
    logic finish;   // clear outputs and release the core
    logic setErr;   // raise the sticky overrun flag
  } seqStrobe_t;

  function automatic logic isEnd(input logic [7:0] b);
    return b == CMD_END;
  endfunction

  function automatic logic isWake(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic isDelay(input logic [7:0] b);
    return b[7:4] == 4'h2;
  endfunction

endpackage

// File: rtl/lpseq_datapath.sv
module lpseq_datapath
  import lpseq_pkg::*;
#(
  parameter int SEQ_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  seqStrobe_t        strobe,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [1:0]        stCode,
  input  logic              busy,
  output logic [7:0]        fetchByte,
  output logic              idxInRange,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] ctlWord,
  output logic [DATA_W-1:0] dlyWord,
  output logic [PWR_W-1:0]  pwrCtl,
  output logic              coreRelease,
  output logic              errFlag
);

  localparam int SEQ_WORDS = SEQ_BYTES / 4;
  localparam int MEM_AW    = $clog2(SEQ_BYTES);

  logic [7:0] seqMem [SEQ_BYTES];

  // register file and sequence memory
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord <= '0;
      ctlWord <= '0;
      dlyWord <= '0;
      for (int i = 0; i < SEQ_BYTES; i++) seqMem[i] <= 8'h00;
    end else if (regWr) begin
      if (regAddr == OFS_CFG) cfgWord <= regWdata;
      if (regAddr == OFS_CTL) ctlWord <= regWdata;
      if (regAddr == OFS_DLY) dlyWord <= regWdata;
      for (int w = 0; w < SEQ_WORDS; w++) begin
        if (regAddr == OFS_SEQ + ADDR_W'(w * 4)) begin
          for (int b = 0; b < 4; b++) seqMem[w*4 + b] <= regWdata[b*8 +: 8];
        end
      end
    end
  end

  // fetch path
  assign idxInRange = curIdx < IDX_W'(SEQ_BYTES);
  assign fetchByte  = idxInRange ? seqMem[curIdx[MEM_AW-1:0]] : 8'h00;

  // status word
  logic [DATA_W-1:0] statusWord;
  always_comb begin
    statusWord          = '0;
    statusWord[0]       = busy;
    statusWord[1]       = errFlag;
    statusWord[4 +: IDX_W] = curIdx;
    statusWord[13:12]   = stCode;
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (regAddr == OFS_CFG)    regRdata = cfgWord;
    if (regAddr == OFS_STATUS) regRdata = statusWord;
    if (regAddr == OFS_CTL)    regRdata = ctlWord;
    if (regAddr == OFS_DLY)    regRdata = dlyWord;
    for (int w = 0; w < SEQ_WORDS; w++) begin
      if (regAddr == OFS_SEQ + ADDR_W'(w * 4))
        regRdata = {seqMem[w*4+3], seqMem[w*4+2], seqMem[w*4+1], seqMem[w*4]};
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCtl      <= '0;
      coreRelease <= 1'b0;
      errFlag     <= 1'b0;
    end else begin
      coreRelease <= strobe.finish;
      if (strobe.finish)      pwrCtl <= '0;
      else if (strobe.setPwr) pwrCtl <= fetchByte[PWR_W-1:0];
      if (strobe.setErr) errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/lpseq_ctrl.sv
module lpseq_ctrl
  import lpseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idleReq,
  input  logic              wakeIrq,
  input  logic [DATA_W-1:0] cfgWord,
  input  logic [DATA_W-1:0] ctlWord,
  input  logic [DATA_W-1:0] dlyWord,
  input  logic [7:0]        fetchByte,
  input  logic              idxInRange,
  output seqStrobe_t        strobe,
  output logic [IDX_W-1:0]  curIdx,
  output logic [1:0]        stCode,
  output logic              busy
);

  seqState_e  state;
  logic       idleQ;
  logic [7:0] divCnt;
  logic [7:0] dlyCnt;
  logic [7:0] divN;
  logic       tick;
  logic       startEdge;
  logic [7:0] dlyField;
  logic       runTick;

  assign divN      = (cfgWord[7:0] == 8'd0) ? 8'd1 : cfgWord[7:0];
  assign busy      = state != ST_IDLE;
  assign tick      = busy && (divCnt == divN - 8'd1);
  assign startEdge = idleReq && !idleQ;
  assign dlyField  = dlyWord[{fetchByte[1:0], 3'b000} +: 8];
  assign runTick   = (state == ST_RUN) && tick;
  assign stCode    = state;

  always_comb begin
    strobe        = '0;
    strobe.finish = runTick && (!idxInRange || isEnd(fetchByte));
    strobe.setErr = runTick && !idxInRange;
    strobe.setPwr = runTick && idxInRange && !isEnd(fetchByte) &&
                    !isWake(fetchByte) && !isDelay(fetchByte);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idleQ  <= 1'b0;
      curIdx <= '0;
      divCnt <= '0;
      dlyCnt <= '0;
    end else begin
      idleQ <= idleReq;
      if (busy) divCnt <= tick ? 8'd0 : divCnt + 8'd1;
      case (state)
        ST_IDLE: begin
          if (startEdge && ctlWord[0]) begin
            state  <= ST_RUN;
            curIdx <= ctlWord[4 +: IDX_W];
            divCnt <= '0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (!idxInRange || isEnd(fetchByte)) begin
              state <= ST_IDLE;
            end else if (isWake(fetchByte)) begin
              state  <= ST_WAIT;
              curIdx <= curIdx + 1'b1;
            end else if (isDelay(fetchByte)) begin
              curIdx <= curIdx + 1'b1;
              if (dlyField != 8'd0) begin
                dlyCnt <= dlyField;
                state  <= ST_DELAY;
              end
            end else begin
              curIdx <= curIdx + 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (tick) begin
            if (dlyCnt == 8'd1) state <= ST_RUN;
            else dlyCnt <= dlyCnt - 8'd1;
          end
        end
        ST_WAIT: begin
          if (wakeIrq) state <= ST_RUN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lpseq_top.sv
module lpseq_top
  import lpseq_pkg::*;
#(
  parameter int SEQ_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              idleReq,
  input  logic              wakeIrq,
  output logic [PWR_W-1:0]  pwrCtl,
  output logic              coreRelease,
  output logic              busy
);

  seqStrobe_t        strobe;
  logic [IDX_W-1:0]  curIdx;
  logic [1:0]        stCode;
  logic [7:0]        fetchByte;
  logic              idxInRange;
  logic [DATA_W-1:0] cfgWord;
  logic [DATA_W-1:0] ctlWord;
  logic [DATA_W-1:0] dlyWord;
  logic              errFlag;
  logic              ctlEn;

  assign ctlEn = ctlWord[0];

  lpseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .idleReq    (idleReq),
    .wakeIrq    (wakeIrq),
    .cfgWord    (cfgWord),
    .ctlWord    (ctlWord),
    .dlyWord    (dlyWord),
    .fetchByte  (fetchByte),
    .idxInRange (idxInRange),
    .strobe     (strobe),
    .curIdx     (curIdx),
    .stCode     (stCode),
    .busy       (busy)
  );

  lpseq_datapath #(.SEQ_BYTES(SEQ_BYTES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regWr       (regWr),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .strobe      (strobe),
    .curIdx      (curIdx),
    .stCode      (stCode),
    .busy        (busy),
    .fetchByte   (fetchByte),
    .idxInRange  (idxInRange),
    .cfgWord     (cfgWord),
    .ctlWord     (ctlWord),
    .dlyWord     (dlyWord),
    .pwrCtl      (pwrCtl),
    .coreRelease (coreRelease),
    .errFlag     (errFlag)
  );

endmodule

// File: rtl/lpseq_checker.sv
module lpseq_checker
  import lpseq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             coreRelease,
  input logic [PWR_W-1:0] pwrCtl,
  input logic             wakeIrq,
  input logic             ctlEn,
  input logic [1:0]       stCode,
  input logic             errFlag,
  input logic [IDX_W-1:0] curIdx
);

  // R1: a start needs the enable bit
  p_start_needs_enable_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ctlEn));

  // R4: release is a single-cycle pulse
  p_release_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    coreRelease |=> !coreRelease);

  // R4: release coincides with the engine being idle
  p_release_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    coreRelease |-> !busy);

  // R4: outputs are cleared whenever the engine is idle
  p_idle_outputs_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (pwrCtl == '0));

  // R5: parked engine holds outputs until wake
  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stCode == 2'b11 && !wakeIrq) |=> (busy && stCode == 2'b11 && $stable(pwrCtl)));

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R10: index never runs beyond one past the last byte while busy
  p_index_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (curIdx <= IDX_W'(32)));

endmodule

bind lpseq_top lpseq_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .coreRelease (coreRelease),
  .pwrCtl      (pwrCtl),
  .wakeIrq     (wakeIrq),
  .ctlEn       (ctlEn),
  .stCode      (stCode),
  .errFlag     (errFlag),
  .curIdx      (curIdx)
);

// File: tb/lpseq_top_bench.sv
module lpseq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 7;

  // {start index, divider, busy cycles, last pwrCtl}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0,  8'd0, 8'd2,  8'h03},
    {8'd0,  8'd1, 8'd2,  8'h03},
    {8'd0,  8'd3, 8'd6,  8'h03},
    {8'd2,  8'd0, 8'd7,  8'h0A},
    {8'd2,  8'd2, 8'd14, 8'h0A},
    {8'd10, 8'd0, 8'd4,  8'h02},
    {8'd10, 8'd4, 8'd16, 8'h02}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        idleReq = 1'b0;
  logic        wakeIrq = 1'b0;
  logic [5:0]  pwrCtl;
  logic        coreRelease;
  logic        busy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  lpseq_top u_lpseq_top (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .idleReq(idleReq),
    .wakeIrq(wakeIrq), .pwrCtl(pwrCtl), .coreRelease(coreRelease), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  // start a program and count busy cycles until it ends
  task automatic runSeq(input int startIdx, input int divVal,
                        output int cycles, output logic [5:0] lastPwr,
                        output logic rel);
    regWrite(12'h008, 32'(divVal));
    regWrite(12'h030, (32'(startIdx) << 4) | 32'h1);
    idleReq = 1'b1;
    cycles = 0; lastPwr = '0; rel = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (busy) begin
        cycles++;
        lastPwr = pwrCtl;
      end else begin
        rel = coreRelease;
        break;
      end
    end
    idleReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    logic [5:0] lp;
    logic rel;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R13 reset busy", {31'b0, busy}, 32'd0);
    check("R4 reset pwrCtl", {26'b0, pwrCtl}, 32'd0);
    regRead(12'h030, rd); check("R13 reset control", rd, 32'd0);
    regRead(12'h00C, rd); check("R10 reset status", rd, 32'd0);

    // register readback
    regWrite(12'h030, 32'h00F0_0050);
    regRead(12'h030, rd); check("R13 control readback", rd, 32'h00F0_0050);
    regWrite(12'h034, 32'h0005_0302);
    regRead(12'h034, rd); check("R13 delay readback", rd, 32'h0005_0302);
    regWrite(12'h008, 32'hAB00_0007);
    regRead(12'h008, rd); check("R13 config readback", rd, 32'hAB00_0007);

    // program image: byte k of word w at bits 8k+7:8k
    regWrite(12'h080, 32'h2105_0F03);
    regWrite(12'h084, 32'h8011_0F0A);
    regWrite(12'h088, 32'h013F_0F22);
    regWrite(12'h08C, 32'h0F80_0F02);
    for (int w = 4; w < 8; w++) regWrite(12'h080 + 12'(w*4), 32'h0101_0101);
    regRead(12'h080, rd); check("R3 word0 readback", rd, 32'h2105_0F03);
    regRead(12'h09C, rd); check("R3 word7 readback", rd, 32'h0101_0101);

    // R1: disabled engine ignores idle edge
    regWrite(12'h030, 32'h0000_0000);
    idleReq = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 disabled busy", {31'b0, busy}, 32'd0);
    check("R1 disabled pwrCtl", {26'b0, pwrCtl}, 32'd0);
    idleReq = 1'b0;
    @(negedge clk);

    // vector table: R2 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      runSeq(int'(VEC[v][31:24]), int'(VEC[v][23:16]), cyc, lp, rel);
      check($sformatf("R8 vec%0d busy cycles", v), 32'(cyc), {24'b0, VEC[v][15:8]});
      check($sformatf("R7 vec%0d last pwrCtl", v), {26'b0, lp}, {24'b0, VEC[v][7:0]});
      check($sformatf("R4 vec%0d release", v), {31'b0, rel}, 32'd1);
      check($sformatf("R4 vec%0d pwr cleared", v), {26'b0, pwrCtl}, 32'd0);
    end

    // R5/R10/R11/R12: park on wake byte at index 7
    regWrite(12'h008, 32'd0);
    regWrite(12'h030, (32'd6 << 4) | 32'h1);
    idleReq = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 parked busy", {31'b0, busy}, 32'd1);
    check("R5 parked pwrCtl", {26'b0, pwrCtl}, 32'h11);
    regRead(12'h00C, rd); check("R10 status while parked", rd, 32'h0000_3081);
    idleReq = 1'b0;
    @(negedge clk);
    idleReq = 1'b1;
    repeat (2) @(negedge clk);
    regRead(12'h00C, rd); check("R11 busy idle edge ignored", rd, 32'h0000_3081);
    regWrite(12'h084, 32'h8033_0F0A);
    regWrite(12'h088, 32'h013F_0F0F);
    wakeIrq = 1'b1;
    @(negedge clk);
    check("R12 fetched byte untouched", {26'b0, pwrCtl}, 32'h11);
    check("R5 resumed busy", {31'b0, busy}, 32'd1);
    @(negedge clk);
    check("R12 new unfetched byte ends run", {31'b0, busy}, 32'd0);
    check("R4 release after wake", {31'b0, coreRelease}, 32'd1);
    wakeIrq = 1'b0; idleReq = 1'b0;
    regWrite(12'h084, 32'h8011_0F0A);
    regWrite(12'h088, 32'h013F_0F22);

    // R5/R6: wake held high, delay field 2 = 5
    wakeIrq = 1'b1;
    runSeq(6, 0, cyc, lp, rel);
    wakeIrq = 1'b0;
    check("R6 wake+delay busy cycles", 32'(cyc), 32'd10);
    check("R7 wake+delay last pwrCtl", {26'b0, lp}, 32'h11);

    // R9: overrun from index 16
    runSeq(16, 0, cyc, lp, rel);
    check("R9 overrun busy cycles", 32'(cyc), 32'd17);
    check("R9 overrun release", {31'b0, rel}, 32'd1);
    regRead(12'h00C, rd); check("R9 error flag set", rd & 32'h3, 32'h2);
    runSeq(0, 0, cyc, lp, rel);
    regRead(12'h00C, rd); check("R9 error flag sticky", rd & 32'h3, 32'h2);
    check("R2 run after error", 32'(cyc), 32'd2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule